// File: doc/BRIEF.md
# PI controller with filter bank

This block is a fixed-point feedback controller for a sample stream running at 125 MHz. Each accepted input sample has a programmable setpoint subtracted from it. The resulting error then passes through four cascaded first-order filter stages. Each stage can be bypassed, or it can act as a lowpass or a highpass, and its corner is set by a power-of-two shift. A proportional path and an integral path work side by side on the filtered error. Their sum is formed at extended width and then clamped between a programmable lower limit and a programmable upper limit.

The integral path keeps a 32-bit saturating accumulator, and its value is always visible on `ival_q`. Software can overwrite the accumulator at any time through a load strobe. The accumulator spans four times the output full scale in either direction, so it can keep winding past the point where the output clamps.

Samples enter and leave on valid/ready handshakes. The whole pipeline advances together in any cycle where the output register is empty or the consumer is ready. `s_ready` is exactly that advance condition. When a result is held because `m_ready` is low, the pipeline stalls, `m_data` stays stable, and no sample is lost or repeated. Configuration pins are plain levels. They are expected to change only while the stream is idle.

Top module: `pi_fb_ctrl`

## Requirements
- R1: After synchronous reset, `m_valid` is 0, `ival_q` is 0, `s_ready` is 1, and every filter state is zero.
- R2: With all stages off, a sample x accepted at a rising edge produces the error e = x - setpoint. The output is clamp(floor(e*kp/256) + floor(acc/65536)), presented as valid two negedges later. kp is signed, and 256 means a gain of 1.
- R3: For each accepted sample, the accumulator adds e_f*ki, where e_f is the filtered error and ki is signed. The result saturates at 0x7FFFFFFF and 0x80000000 and never wraps. A ki code of 1 adds exactly e_f.
- R4: When `ival_load` is high at a clock edge, the accumulator takes `ival_data` at that edge. This takes priority over an accumulation in the same cycle.
- R5: The output always lies within [out_min, out_max]. The sum is formed at full width, so a large positive sum clamps to out_max and never flips sign.
- R6: A zero gain disables its path. With kp = 0 only the integral term reaches the output. With ki = 0 the accumulator holds its value.
- R7: A stage in mode 1 is a lowpass with shift k, taken from its 4-bit field. Its state updates as y += (x*65536 - y) >>> k, and its output is saturate15(y >>> 16).
- R8: A stage in mode 2 is a highpass. Its output is saturate15(x - (y >>> 16)), using the same state update as R7. Modes 0 and 3 bypass the stage. Stage i uses bits [2i+1:2i] of `flt_mode` and bits [4i+3:4i] of `flt_shift`. Stage 0 is first in the chain.
- R9: Each enabled stage adds exactly two cycles of latency, and a bypassed stage adds none.
- R10: While `m_valid` is high and `m_ready` is low, `s_ready` is low and `m_data` is stable. All accepted samples come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | 14 | Signed input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Consumer takes the output |
| m_data | output | 14 | Signed clamped controller output |
| setpoint | input | 14 | Signed setpoint |
| kp | input | 16 | Signed proportional gain, 256 = 1.0 |
| ki | input | 16 | Signed integral gain per sample |
| out_max | input | 14 | Signed upper output limit |
| out_min | input | 14 | Signed lower output limit |
| flt_mode | input | 8 | Two-bit mode per stage: 0 off, 1 lowpass, 2 highpass, 3 off |
| flt_shift | input | 16 | Four-bit corner shift per stage |
| ival_load | input | 1 | Accumulator load strobe |
| ival_data | input | 32 | Value written on load |
| ival_q | output | 32 | Current accumulator value |

## Verification
The limit property assumes that out_min is never above out_max. It also assumes the limits do not change while a result is pending. The stimulus therefore moves the limits only after the stream has drained. The properties further assume that configuration pins stay steady while samples are in flight and that `m_ready` is driven only by the consumer. The bench keeps to this by reprogramming modes, shifts and gains only between bursts, after every expected result has come out.

// File: rtl/pi_fb_pkg.sv
package pi_fb_pkg;
  typedef enum logic [1:0] {
    FLT_OFF  = 2'd0,
    FLT_LOW  = 2'd1,
    FLT_HIGH = 2'd2,
    FLT_BYP  = 2'd3
  } flt_mode_e;
endpackage

// File: rtl/pi_fb_stage.sv
module pi_fb_stage
  import pi_fb_pkg::*;
#(
  parameter int EW   = 15,
  parameter int SH_W = 4,
  parameter int FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [1:0]           mode,
  input  logic [SH_W-1:0]      shift,
  input  logic                 in_v,
  input  logic signed [EW-1:0] in_d,
  output logic                 out_v,
  output logic signed [EW-1:0] out_d
);
  localparam int YW = EW + FRAC + 1;
  localparam int DW = YW + 1;
  localparam logic signed [YW-1:0] MAXV = {{(YW-EW+1){1'b0}}, {(EW-1){1'b1}}};
  localparam logic signed [YW-1:0] MINV = {{(YW-EW+1){1'b1}}, {(EW-1){1'b0}}};

  logic                 en;
  logic signed [YW-1:0] y_q;
  logic signed [EW-1:0] x_q;
  logic signed [EW-1:0] o_q;
  logic                 v1_q, v2_q;
  logic signed [DW-1:0] diff, step, y_sum;
  logic signed [YW-1:0] lp_full, hp_full, pick;

  assign en = (mode == FLT_LOW) || (mode == FLT_HIGH);

  // state update: y moves toward x*2^FRAC by a power-of-two fraction
  always_comb begin
    diff  = (DW'(in_d) <<< FRAC) - DW'(y_q);
    step  = diff >>> shift;
    y_sum = DW'(y_q) + step;
  end

  // output formed from the updated state of the sample held in x_q
  always_comb begin
    lp_full = y_q >>> FRAC;
    hp_full = YW'(x_q) - lp_full;
    pick    = (mode == FLT_HIGH) ? hp_full : lp_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q  <= '0;
      x_q  <= '0;
      o_q  <= '0;
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (adv) begin
      v1_q <= in_v & en;
      x_q  <= in_d;
      if (in_v && en) y_q <= y_sum[YW-1:0];
      v2_q <= v1_q;
      if (pick > MAXV)      o_q <= MAXV[EW-1:0];
      else if (pick < MINV) o_q <= MINV[EW-1:0];
      else                  o_q <= pick[EW-1:0];
    end
  end

  assign out_v = en ? v2_q : in_v;
  assign out_d = en ? o_q  : in_d;
endmodule

// File: rtl/pi_fb_core.sv
module pi_fb_core #(
  parameter int IW  = 14,
  parameter int KW  = 16,
  parameter int AW  = 32,
  parameter int PSH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic                   in_v,
  input  logic signed [IW:0]     err,
  input  logic signed [KW-1:0]   kp,
  input  logic signed [KW-1:0]   ki,
  input  logic signed [IW-1:0]   out_max,
  input  logic signed [IW-1:0]   out_min,
  input  logic                   load,
  input  logic signed [AW-1:0]   load_d,
  output logic                   out_v,
  output logic signed [IW-1:0]   out_d,
  output logic signed [AW-1:0]   acc_q
);
  localparam int EW  = IW + 1;
  localparam int PW  = EW + KW;
  localparam int ISH = AW - IW - 2;
  localparam int PTW = PW - PSH;
  localparam int ITW = AW - ISH;
  localparam int SW  = ((PTW > ITW) ? PTW : ITW) + 1;
  localparam int AW1 = AW + 1;
  localparam logic signed [AW:0] AMAX = {2'b00, {(AW-1){1'b1}}};
  localparam logic signed [AW:0] AMIN = {2'b11, {(AW-1){1'b0}}};

  logic signed [PW-1:0]  prod_i, p_q, p_shift;
  logic signed [AW:0]    acc_sum;
  logic signed [AW-1:0]  acc_sat, i_shift;
  logic signed [SW-1:0]  sum, lim_hi, lim_lo;
  logic                  va_q;

  always_comb begin
    prod_i  = PW'(err) * PW'(ki);
    acc_sum = AW1'(acc_q) + AW1'(prod_i);
    if (acc_sum > AMAX)      acc_sat = AMAX[AW-1:0];
    else if (acc_sum < AMIN) acc_sat = AMIN[AW-1:0];
    else                     acc_sat = acc_sum[AW-1:0];
  end

  always_comb begin
    p_shift = p_q >>> PSH;
    i_shift = acc_q >>> ISH;
    sum     = SW'(p_shift) + SW'(i_shift);
    lim_hi  = SW'(out_max);
    lim_lo  = SW'(out_min);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      p_q   <= '0;
      va_q  <= 1'b0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      if (load)             acc_q <= load_d;
      else if (adv && in_v) acc_q <= acc_sat;
      if (adv) begin
        va_q  <= in_v;
        p_q   <= PW'(err) * PW'(kp);
        out_v <= va_q;
        if (sum > lim_hi)      out_d <= out_max;
        else if (sum < lim_lo) out_d <= out_min;
        else                   out_d <= sum[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/pi_fb_ctrl.sv
module pi_fb_ctrl #(
  parameter int IW   = 14,
  parameter int KW   = 16,
  parameter int AW   = 32,
  parameter int NSTG = 4,
  parameter int SH_W = 4,
  parameter int FRAC = 16,
  parameter int PSH  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [IW-1:0]        s_data,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [IW-1:0]        m_data,
  input  logic [IW-1:0]        setpoint,
  input  logic [KW-1:0]        kp,
  input  logic [KW-1:0]        ki,
  input  logic [IW-1:0]        out_max,
  input  logic [IW-1:0]        out_min,
  input  logic [2*NSTG-1:0]    flt_mode,
  input  logic [SH_W*NSTG-1:0] flt_shift,
  input  logic                 ival_load,
  input  logic [AW-1:0]        ival_data,
  output logic [AW-1:0]        ival_q
);
  localparam int EW = IW + 1;

  logic                 adv;
  logic                 v0_q;
  logic signed [EW-1:0] e0_q;
  logic                 ch_v [NSTG+1];
  logic signed [EW-1:0] ch_d [NSTG+1];
  logic signed [IW-1:0] out_d;
  logic signed [AW-1:0] acc;

  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q <= 1'b0;
      e0_q <= '0;
    end else if (adv) begin
      v0_q <= s_valid;
      e0_q <= EW'($signed(s_data)) - EW'($signed(setpoint));
    end
  end

  assign ch_v[0] = v0_q;
  assign ch_d[0] = e0_q;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    pi_fb_stage #(.EW(EW), .SH_W(SH_W), .FRAC(FRAC)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .mode  (flt_mode[2*g +: 2]),
      .shift (flt_shift[SH_W*g +: SH_W]),
      .in_v  (ch_v[g]),
      .in_d  (ch_d[g]),
      .out_v (ch_v[g+1]),
      .out_d (ch_d[g+1])
    );
  end

  pi_fb_core #(.IW(IW), .KW(KW), .AW(AW), .PSH(PSH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .in_v    (ch_v[NSTG]),
    .err     (ch_d[NSTG]),
    .kp      ($signed(kp)),
    .ki      ($signed(ki)),
    .out_max ($signed(out_max)),
    .out_min ($signed(out_min)),
    .load    (ival_load),
    .load_d  ($signed(ival_data)),
    .out_v   (m_valid),
    .out_d   (out_d),
    .acc_q   (acc)
  );

  assign m_data = out_d;
  assign ival_q = acc;
endmodule

// File: rtl/pi_fb_ctrl_chk.sv
module pi_fb_ctrl_chk #(
  parameter int IW = 14,
  parameter int KW = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [IW-1:0] m_data,
  input logic [IW-1:0] out_max,
  input logic [IW-1:0] out_min,
  input logic [KW-1:0] ki,
  input logic          ival_load,
  input logic [AW-1:0] ival_data,
  input logic [AW-1:0] ival_q
);
  logic rst_d;

  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_clear_R1: assert (!m_valid && ival_q == '0 && s_ready);
    end
    rst_d <= rst;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |-> !s_ready);

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    ival_load |=> ival_q == $past(ival_data));

  assert_limits_R5: assert property (@(posedge clk) disable iff (rst)
    m_valid && $stable(out_max) && $stable(out_min) |->
      ($signed(m_data) <= $signed(out_max)) && ($signed(m_data) >= $signed(out_min)));

  assert_ki_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ki == '0 && !ival_load |=> $stable(ival_q));
endmodule

bind pi_fb_ctrl pi_fb_ctrl_chk #(.IW(IW), .KW(KW), .AW(AW)) u_chk (.*);

// File: tb/pi_fb_ctrl_test.sv
`timescale 1ns/1ps
module pi_fb_ctrl_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               s_valid = 1'b0;
  logic               s_ready;
  logic signed [13:0] s_data = '0;
  logic               m_valid;
  logic               m_ready = 1'b1;
  logic [13:0]        m_data;
  logic signed [13:0] setpoint = '0;
  logic signed [15:0] kp = 16'sd256;
  logic signed [15:0] ki = '0;
  logic signed [13:0] out_max = 14'sd8191;
  logic signed [13:0] out_min = -14'sd8192;
  logic [7:0]         flt_mode = '0;
  logic [15:0]        flt_shift = '0;
  logic               ival_load = 1'b0;
  logic [31:0]        ival_data = '0;
  logic [31:0]        ival_q;

  int     n_chk = 0;
  int     n_bad = 0;
  string  cur_req = "R2";
  longint exp_q[$];
  longint acc_m = 0;
  longint y_m[4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  pi_fb_ctrl uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .setpoint(setpoint),
    .kp(kp), .ki(ki), .out_max(out_max), .out_min(out_min), .flt_mode(flt_mode),
    .flt_shift(flt_shift), .ival_load(ival_load), .ival_data(ival_data), .ival_q(ival_q)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input int w);
    longint mx = (longint'(1) <<< (w - 1)) - 1;
    if (v > mx) return mx;
    if (v < -mx - 1) return -mx - 1;
    return v;
  endfunction

  function automatic longint model(input longint x);
    longint e, d, lp, s;
    e = x - longint'(setpoint);
    for (int i = 0; i < 4; i++) begin
      if (flt_mode[2*i +: 2] == 2'd1 || flt_mode[2*i +: 2] == 2'd2) begin
        d = e * 65536 - y_m[i];
        y_m[i] = y_m[i] + (d >>> int'(flt_shift[4*i +: 4]));
        lp = y_m[i] >>> 16;
        e = sat((flt_mode[2*i +: 2] == 2'd2) ? e - lp : lp, 15);
      end
    end
    acc_m = sat(acc_m + e * longint'(ki), 32);
    s = ((e * longint'(kp)) >>> 8) + (acc_m >>> 16);
    if (s > longint'(out_max)) s = longint'(out_max);
    else if (s < longint'(out_min)) s = longint'(out_min);
    return s;
  endfunction

  task automatic send_raw(input logic signed [13:0] x, input longint exp);
    bit ok;
    exp_q.push_back(exp);
    s_valid = 1'b1;
    s_data  = x;
    forever begin
      #1 ok = s_ready;
      @(negedge clk);
      if (ok) break;
    end
    s_valid = 1'b0;
  endtask

  task automatic send(input logic signed [13:0] x);
    send_raw(x, model(longint'(x)));
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    acc_m = 0;
    for (int i = 0; i < 4; i++) y_m[i] = 0;
  endtask

  task automatic load_acc(input logic [31:0] v);
    ival_load = 1'b1;
    ival_data = v;
    @(negedge clk);
    ival_load = 1'b0;
    acc_m = longint'($signed(v));
  endtask

  task automatic send_lat(input logic signed [13:0] x, input int exp_lat, input string req);
    int cnt = 0;
    send(x);
    #1;
    while (!m_valid && cnt < 40) begin
      @(negedge clk);
      #1 cnt++;
    end
    chk(req, cnt, exp_lat);
    drain();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on each output transfer
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) chk({cur_req, " unexpected output"}, longint'($signed(m_data)), -99999);
        else chk(cur_req, longint'($signed(m_data)), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [13:0] held;
    @(negedge clk);
    do_reset();
    #1;
    chk("R1 m_valid", m_valid, 0);
    chk("R1 ival_q", ival_q, 0);
    chk("R1 s_ready", s_ready, 1);
    @(negedge clk);

    // proportional path, filters bypassed
    cur_req = "R2";
    setpoint = 14'sd100;
    send(14'sd1000);
    send(-14'sd3000);
    send(14'sd8191);
    send(-14'sd8192);
    kp = 16'sd512;
    send(14'sd3000);
    drain();
    chk("R6 ival_q held with ki=0", ival_q, 0);
    kp = 16'sd256;
    send_lat(14'sd500, 2, "R9 latency no stages");

    // integral path
    do_reset();
    cur_req = "R3";
    kp = 16'sd0; ki = 16'sd1; setpoint = '0;
    send(14'sd500); send(14'sd300); send(-14'sd100);
    drain();
    chk("R3 acc after ki=1", longint'($signed(ival_q)), 700);
    ki = -16'sd3;
    send(14'sd1000);
    drain();
    chk("R3 acc negative", longint'($signed(ival_q)), -2300);
    cur_req = "R6";
    ki = 16'sd0;
    send(14'sd4000); send(-14'sd4000);
    drain();
    chk("R6 acc stable ki=0", longint'($signed(ival_q)), -2300);

    // load
    cur_req = "R4";
    load_acc(32'h0012_3456);
    #1 chk("R4 load value", ival_q, 32'h0012_3456);
    @(negedge clk);
    ki = 16'sd1;
    send(14'sd16);
    drain();
    send_raw(14'sd5, 5);
    load_acc(32'h0005_0000);
    drain();
    chk("R4 load beats accumulate", ival_q, 32'h0005_0000);

    // saturation of the accumulator
    cur_req = "R3";
    ki = 16'sd16384;
    load_acc(32'h7FFF_0000);
    send(14'sd8191);
    send(14'sd8191);
    drain();
    chk("R3 positive saturation", ival_q, 32'h7FFF_FFFF);
    load_acc(32'h8001_0000);
    send(-14'sd8192);
    drain();
    chk("R3 negative saturation", ival_q, 32'h8000_0000);

    // output limits
    do_reset();
    cur_req = "R5";
    ki = '0; kp = 16'sd256;
    out_max = 14'sd1000; out_min = -14'sd500;
    send(14'sd3000); send(-14'sd2000); send(14'sd200); send(14'sd1000);
    drain();
    out_max = 14'sd8191; out_min = -14'sd8192;
    @(negedge clk);
    kp = 16'sd32767;
    send(14'sd8191); send(-14'sd8192);
    drain();
    kp = 16'sd256;

    // lowpass stage 0, shift 2
    do_reset();
    cur_req = "R7";
    flt_mode = 8'h01; flt_shift = 16'h0002;
    send_raw(14'sd4000, 1000);
    y_m[0] = 1000 * 65536;
    drain();
    do_reset();
    send_lat(14'sd4000, 4, "R9 latency one stage");
    for (int i = 0; i < 5; i++) send(14'sd4000);
    for (int i = 0; i < 3; i++) send(-14'sd1000);
    drain();

    // highpass stage 1 shift 3, then lowpass stage 3 shift 1
    do_reset();
    cur_req = "R8";
    flt_mode = 8'h08; flt_shift = 16'h0030;
    send_raw(14'sd2000, 1750);
    drain();
    do_reset();
    flt_mode = 8'h48; flt_shift = 16'h1030;
    send_lat(14'sd2000, 6, "R9 latency two stages");
    for (int i = 0; i < 4; i++) send(14'sd2000);
    for (int i = 0; i < 3; i++) send(14'sd0);
    drain();

    // back-pressure
    do_reset();
    cur_req = "R10";
    flt_mode = '0; flt_shift = '0;
    m_ready = 1'b0;
    fork
      begin
        send(14'sd11); send(14'sd22); send(14'sd33); send(14'sd44);
      end
      begin
        repeat (12) @(negedge clk);
        #1;
        chk("R10 s_ready low while held", s_ready, 0);
        chk("R10 m_valid held", m_valid, 1);
        held = m_data;
        @(negedge clk);
        #1 chk("R10 m_data stable", m_data, held);
        @(negedge clk);
        m_ready = 1'b1;
      end
    join
    drain();
    chk("R10 all samples delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule